// File: doc/BRIEF.md
# Interrupt Request and End-of-Interrupt Engine

This block holds the per-pin request state of an I/O interrupt router. Each clock it samples the input pins and converts each one to an effective level with that pin's polarity setting. It keeps a pending bit for every pin. For level-triggered pins it also keeps a remote-IRR bit. From this state it decides when a pin should be serviced, and it then issues a delivery message built from that pin's routing entry. The message leaves on a valid/ready handshake. A side input, `dlv_ok`, tells the block whether the processor side took the interrupt.

End-of-interrupt notices arrive with a vector number and a type flag. Each notice is checked against a registered map of the vectors present in the routing table, and that map is rebuilt whenever an entry write is flagged. A notice that gets through produces an acknowledge pulse on every pin carrying that vector. A level-type notice also releases those pins and queues them for service again. Requests that cannot be serviced because the pin is still in service are reported on a per-pin coalesced output. The routing entries are supplied flattened on ports by a register block outside this engine.

Top module: `irq_eoi_engine`

## Requirements
- R1: The effective level of pin i is `pin_level[i] XOR ent_active_low[i]`. All other rules use only the effective level.
- R2: An edge-triggered pin (`ent_level_trig[i]=0`) requests service once per low-to-high change of its effective level. Holding the level high or driving it low produces no further delivery.
- R3: A level-triggered pin (`ent_level_trig[i]=1`) requests service on a low-to-high change only while its remote-IRR is clear. A handshake with `dlv_ok=1` for a level-triggered message sets that pin's remote-IRR. A handshake with `dlv_ok=0` leaves it clear.
- R4: A low-to-high change on a level-triggered pin whose remote-IRR is set produces no delivery. Instead, `coalesced[i]` is high for exactly one cycle.
- R5: A pin whose mask bit is set when its request is picked is dropped. No message is issued for it.
- R6: A message carries the vector, destination, destination-mode bit, trigger bit, 3-bit delivery mode and pin number of the entry at launch. The message stays stable while `dlv_valid=1` and `dlv_ready=0`.
- R7: Pending requests are launched one at a time in ascending pin order. A new message is loaded only when no message is outstanding.
- R8: A notice that is accepted pulses `eoi_ack[i]` for one cycle on every pin whose vector equals `eoi_vector`. The pulse comes in the cycle after the notice.
- R9: A level-type notice (`eoi_level=1`) clears remote-IRR on matching pins. It re-queues each matching level-triggered pin that is unmasked and whose effective level is high. A notice with `eoi_level=0` leaves remote-IRR unchanged.
- R10: A notice whose vector is absent from the vector map is ignored. The map is cleared by reset and rebuilt from all entries in the cycle after any `ent_wr` pulse.
- R11: An `ent_wr[i]` pulse on a level-triggered pin with a high effective level queues that pin for service, whatever its remote-IRR state. An `ent_wr[i]` pulse on an edge-triggered pin does not queue it.
- R12: If an accepted level-triggered handshake and a level-type notice hit the same pin in the same cycle, remote-IRR ends set.
- R13: Reset clears all pending, remote-IRR and queued state. While reset is held, `dlv_valid`, `coalesced` and `eoi_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_PINS | Raw pin inputs, sampled every clock |
| ent_vector | input | NUM_PINS*8 | Vector of each entry, pin i at bits [8i+7:8i] |
| ent_dest | input | NUM_PINS*8 | Destination of each entry |
| ent_dest_logical | input | NUM_PINS | Destination-mode bit per entry |
| ent_level_trig | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| ent_dmode | input | NUM_PINS*3 | Delivery mode per entry, pin i at bits [3i+2:3i] |
| ent_active_low | input | NUM_PINS | Polarity per entry, 1 = input inverted |
| ent_mask | input | NUM_PINS | Mask per entry |
| ent_wr | input | NUM_PINS | One-cycle pulse: entry i was written |
| eoi_valid | input | 1 | End-of-interrupt notice present |
| eoi_vector | input | 8 | Vector of the notice |
| eoi_level | input | 1 | 1 = level-type notice |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery message taken this cycle |
| dlv_ok | input | 1 | Interrupt accepted, qualifies the handshake |
| dlv_vector | output | 8 | Message vector |
| dlv_dest | output | 8 | Message destination |
| dlv_dest_logical | output | 1 | Message destination mode |
| dlv_level_trig | output | 1 | Message trigger mode |
| dlv_dmode | output | 3 | Message delivery mode |
| dlv_pin | output | $clog2(NUM_PINS) | Pin that produced the message |
| coalesced | output | NUM_PINS | One-cycle pulse per coalesced request |
| eoi_ack | output | NUM_PINS | One-cycle acknowledge per matching pin |

## Verification
The main collision is on a level-triggered pin's remote-IRR: a message for that pin is taken with `dlv_ok=1` in the same cycle that a level-type notice for its vector arrives, so one event sets the bit and the other clears it. The bench sets this up by holding a redelivered message with `dlv_ready` low. It then raises `dlv_ready` in the same cycle as the notice. It drops `dlv_ok` before the follow-up redelivery, so that message cannot set remote-IRR again. The outcome is judged at the ports: after the pin toggles, a coalesced pulse with no new message shows that the set won. A second overlap is a stale vector map against a changed entry vector: a notice for the new vector is sent before and after the `ent_wr` pulse, and only the notice after the pulse may acknowledge.

// File: rtl/irq_eoi_pkg.sv
package irq_eoi_pkg;

    localparam int VEC_W   = 8;
    localparam int DEST_W  = 8;
    localparam int DMODE_W = 3;
    localparam int VEC_NUM = 1 << VEC_W;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic [DEST_W-1:0]  dest;
        logic [VEC_W-1:0]   vector;
        logic               dest_logical;
        trig_e              trig;
        logic [DMODE_W-1:0] dmode;
        logic               active_low;
        logic               masked;
    } route_entry_t;

    typedef struct packed {
        logic [DEST_W-1:0]  dest;
        logic [VEC_W-1:0]   vector;
        logic               dest_logical;
        trig_e              trig;
        logic [DMODE_W-1:0] dmode;
    } dlv_msg_t;

    function automatic dlv_msg_t make_msg(input route_entry_t e);
        dlv_msg_t m;
        m.dest         = e.dest;
        m.vector       = e.vector;
        m.dest_logical = e.dest_logical;
        m.trig         = e.trig;
        m.dmode        = e.dmode;
        return m;
    endfunction

endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_eoi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic             alow,
    input  logic             lvl_trig,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             entry_wr,
    input  logic             eoi_fire,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             grant,
    input  logic             accept,
    output logic             svc_req,
    output logic             coalesced,
    output logic             eoi_ack
);

    logic pend_q;
    logic rirr_q;
    logic svc_q;
    logic coal_q;
    logic ack_q;

    logic eff;
    logic rise;
    logic vec_hit;
    logic serve_new;
    logic coal_now;
    logic eoi_redo;
    logic wr_redo;
    logic rirr_next;

    always_comb begin
        eff       = pin_in ^ alow;
        rise      = eff & ~pend_q;
        vec_hit   = eoi_fire && (vector == eoi_vector);
        serve_new = rise && (!lvl_trig || !rirr_q);
        coal_now  = rise && lvl_trig && rirr_q;
        eoi_redo  = vec_hit && eoi_level && lvl_trig && eff && !masked;
        wr_redo   = entry_wr && lvl_trig && eff;
        // an accepted delivery outranks a release in the same cycle
        if (accept)
            rirr_next = 1'b1;
        else if (vec_hit && eoi_level)
            rirr_next = 1'b0;
        else
            rirr_next = rirr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
            svc_q  <= 1'b0;
            coal_q <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            pend_q <= eff;
            rirr_q <= rirr_next;
            svc_q  <= (svc_q & ~grant) | serve_new | eoi_redo | wr_redo;
            coal_q <= coal_now;
            ack_q  <= vec_hit;
        end
    end

    assign svc_req   = svc_q;
    assign coalesced = coal_q;
    assign eoi_ack   = ack_q;

endmodule

// File: rtl/irq_vec_filter.sv
module irq_vec_filter
    import irq_eoi_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_PINS-1:0][VEC_W-1:0]  vectors,
    input  logic [NUM_PINS-1:0]             entry_wr,
    input  logic                            eoi_valid,
    input  logic [VEC_W-1:0]                eoi_vector,
    output logic                            eoi_fire
);

    logic [VEC_NUM-1:0] map_q;
    logic [VEC_NUM-1:0] map_c;

    always_comb begin
        map_c = '0;
        for (int i = 0; i < NUM_PINS; i++)
            map_c[vectors[i]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else if (|entry_wr)
            map_q <= map_c;
    end

    assign eoi_fire = eoi_valid && map_q[eoi_vector];

endmodule

// File: rtl/irq_dlv_arbiter.sv
module irq_dlv_arbiter
    import irq_eoi_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PINS-1:0]           svc_req,
    input  logic [NUM_PINS-1:0]           cand_mask,
    input  dlv_msg_t [NUM_PINS-1:0]       cand_msg,
    input  logic                          dlv_ready,
    input  logic                          dlv_ok,
    output logic [NUM_PINS-1:0]           grant,
    output logic [NUM_PINS-1:0]           accept,
    output logic                          dlv_valid,
    output dlv_msg_t                      dlv_msg,
    output logic [PIN_W-1:0]              dlv_pin
);

    logic             valid_q;
    dlv_msg_t         msg_q;
    logic [PIN_W-1:0] pin_q;

    logic             found;
    logic [PIN_W-1:0] pick;
    logic             launch;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (svc_req[i]) begin
                found = 1'b1;
                pick  = PIN_W'(i);
            end
        end
        grant  = '0;
        launch = 1'b0;
        if (!valid_q && found) begin
            grant[pick] = 1'b1;
            launch      = !cand_mask[pick];
        end
        accept = '0;
        if (valid_q && dlv_ready && dlv_ok && msg_q.trig == TRIG_LEVEL)
            accept[pin_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
            pin_q   <= '0;
        end else if (launch) begin
            valid_q <= 1'b1;
            msg_q   <= cand_msg[pick];
            pin_q   <= pick;
        end else if (valid_q && dlv_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign dlv_valid = valid_q;
    assign dlv_msg   = msg_q;
    assign dlv_pin   = pin_q;

endmodule

// File: rtl/irq_eoi_engine.sv
module irq_eoi_engine
    import irq_eoi_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         pin_level,
    input  logic [NUM_PINS*VEC_W-1:0]   ent_vector,
    input  logic [NUM_PINS*DEST_W-1:0]  ent_dest,
    input  logic [NUM_PINS-1:0]         ent_dest_logical,
    input  logic [NUM_PINS-1:0]         ent_level_trig,
    input  logic [NUM_PINS*DMODE_W-1:0] ent_dmode,
    input  logic [NUM_PINS-1:0]         ent_active_low,
    input  logic [NUM_PINS-1:0]         ent_mask,
    input  logic [NUM_PINS-1:0]         ent_wr,
    input  logic                        eoi_valid,
    input  logic [VEC_W-1:0]            eoi_vector,
    input  logic                        eoi_level,
    output logic                        dlv_valid,
    input  logic                        dlv_ready,
    input  logic                        dlv_ok,
    output logic [VEC_W-1:0]            dlv_vector,
    output logic [DEST_W-1:0]           dlv_dest,
    output logic                        dlv_dest_logical,
    output logic                        dlv_level_trig,
    output logic [DMODE_W-1:0]          dlv_dmode,
    output logic [PIN_W-1:0]            dlv_pin,
    output logic [NUM_PINS-1:0]         coalesced,
    output logic [NUM_PINS-1:0]         eoi_ack
);

    route_entry_t [NUM_PINS-1:0]      ent;
    dlv_msg_t     [NUM_PINS-1:0]      cand_msg;
    logic         [NUM_PINS-1:0][VEC_W-1:0] vec_arr;
    logic         [NUM_PINS-1:0]      svc_req;
    logic         [NUM_PINS-1:0]      grant;
    logic         [NUM_PINS-1:0]      accept;
    logic                             eoi_fire;
    dlv_msg_t                         msg;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign ent[g].dest         = ent_dest[g*DEST_W +: DEST_W];
        assign ent[g].vector       = ent_vector[g*VEC_W +: VEC_W];
        assign ent[g].dest_logical = ent_dest_logical[g];
        assign ent[g].trig         = trig_e'(ent_level_trig[g]);
        assign ent[g].dmode        = ent_dmode[g*DMODE_W +: DMODE_W];
        assign ent[g].active_low   = ent_active_low[g];
        assign ent[g].masked       = ent_mask[g];
        assign cand_msg[g]         = make_msg(ent[g]);
        assign vec_arr[g]          = ent[g].vector;

        irq_pin_ctrl u_pin (
            .clk        (clk),
            .rst        (rst),
            .pin_in     (pin_level[g]),
            .alow       (ent[g].active_low),
            .lvl_trig   (ent[g].trig == TRIG_LEVEL),
            .masked     (ent[g].masked),
            .vector     (ent[g].vector),
            .entry_wr   (ent_wr[g]),
            .eoi_fire   (eoi_fire),
            .eoi_vector (eoi_vector),
            .eoi_level  (eoi_level),
            .grant      (grant[g]),
            .accept     (accept[g]),
            .svc_req    (svc_req[g]),
            .coalesced  (coalesced[g]),
            .eoi_ack    (eoi_ack[g])
        );
    end

    irq_vec_filter #(.NUM_PINS(NUM_PINS)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .vectors    (vec_arr),
        .entry_wr   (ent_wr),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .eoi_fire   (eoi_fire)
    );

    irq_dlv_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .svc_req   (svc_req),
        .cand_mask (ent_mask),
        .cand_msg  (cand_msg),
        .dlv_ready (dlv_ready),
        .dlv_ok    (dlv_ok),
        .grant     (grant),
        .accept    (accept),
        .dlv_valid (dlv_valid),
        .dlv_msg   (msg),
        .dlv_pin   (dlv_pin)
    );

    assign dlv_vector       = msg.vector;
    assign dlv_dest         = msg.dest;
    assign dlv_dest_logical = msg.dest_logical;
    assign dlv_level_trig   = (msg.trig == TRIG_LEVEL);
    assign dlv_dmode        = msg.dmode;

endmodule

// File: rtl/irq_eoi_engine_chk.sv
module irq_eoi_engine_chk #(
    parameter int NUM_PINS = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] ent_mask,
    input logic [NUM_PINS-1:0] ent_level_trig,
    input logic                eoi_valid,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [7:0]          dlv_vector,
    input logic [7:0]          dlv_dest,
    input logic [PIN_W-1:0]    dlv_pin,
    input logic [NUM_PINS-1:0] coalesced,
    input logic [NUM_PINS-1:0] eoi_ack
);

    // R13
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dlv_valid && coalesced == '0 && eoi_ack == '0));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector)
                                       && $stable(dlv_dest) && $stable(dlv_pin)));

    // R5
    no_masked_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !$past(dlv_valid)) |->
            (($past(ent_mask) & (NUM_PINS'(1) << dlv_pin)) == '0));

    // R4
    coalesce_level_only_chk: assert property (@(posedge clk) disable iff (rst)
        (coalesced & ~$past(ent_level_trig)) == '0);

    // R8
    ack_needs_notice_chk: assert property (@(posedge clk) disable iff (rst)
        (|eoi_ack) |-> $past(eoi_valid));

endmodule

bind irq_eoi_engine irq_eoi_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ent_mask       (ent_mask),
    .ent_level_trig (ent_level_trig),
    .eoi_valid      (eoi_valid),
    .dlv_valid      (dlv_valid),
    .dlv_ready      (dlv_ready),
    .dlv_vector     (dlv_vector),
    .dlv_dest       (dlv_dest),
    .dlv_pin        (dlv_pin),
    .coalesced      (coalesced),
    .eoi_ack        (eoi_ack)
);

// File: tb/test_irq_eoi_engine.sv
`timescale 1ns/1ps
module test_irq_eoi_engine;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   pin_level = '0;
    logic [N*8-1:0] ent_vector = '0;
    logic [N*8-1:0] ent_dest = '0;
    logic [N-1:0]   ent_dest_logical = '0;
    logic [N-1:0]   ent_level_trig = '0;
    logic [N*3-1:0] ent_dmode = '0;
    logic [N-1:0]   ent_active_low = '0;
    logic [N-1:0]   ent_mask = '0;
    logic [N-1:0]   ent_wr = '0;
    logic           eoi_valid = 1'b0;
    logic [7:0]     eoi_vector = '0;
    logic           eoi_level = 1'b0;
    logic           dlv_valid;
    logic           dlv_ready = 1'b1;
    logic           dlv_ok = 1'b1;
    logic [7:0]     dlv_vector;
    logic [7:0]     dlv_dest;
    logic           dlv_dest_logical;
    logic           dlv_level_trig;
    logic [2:0]     dlv_dmode;
    logic [2:0]     dlv_pin;
    logic [N-1:0]   coalesced;
    logic [N-1:0]   eoi_ack;

    always #10 clk = ~clk;

    irq_eoi_engine #(.NUM_PINS(N)) i_irq_eoi_engine (
        .clk(clk), .rst(rst), .pin_level(pin_level),
        .ent_vector(ent_vector), .ent_dest(ent_dest),
        .ent_dest_logical(ent_dest_logical), .ent_level_trig(ent_level_trig),
        .ent_dmode(ent_dmode), .ent_active_low(ent_active_low),
        .ent_mask(ent_mask), .ent_wr(ent_wr),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_ok(dlv_ok),
        .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_dest_logical(dlv_dest_logical), .dlv_level_trig(dlv_level_trig),
        .dlv_dmode(dlv_dmode), .dlv_pin(dlv_pin),
        .coalesced(coalesced), .eoi_ack(eoi_ack)
    );

    int checks = 0;
    int fails  = 0;
    int dcount = 0;
    int rec_pin [256];
    int rec_vec [256];
    int rec_dest[256];
    int rec_dm  [256];
    int rec_lg  [256];
    int rec_lt  [256];
    int co_cnt  [N];
    int ack_cnt [N];
    bit cur_eff [N];

    initial begin
        for (int i = 0; i < N; i++) begin
            co_cnt[i]  = 0;
            ack_cnt[i] = 0;
            cur_eff[i] = 1'b0;
        end
    end

    // handshake and pulse monitor, reads pre-edge values
    always @(posedge clk) begin
        if (!rst) begin
            if (dlv_valid && dlv_ready) begin
                if (dcount < 256) begin
                    rec_pin[dcount]  = int'(dlv_pin);
                    rec_vec[dcount]  = int'(dlv_vector);
                    rec_dest[dcount] = int'(dlv_dest);
                    rec_dm[dcount]   = int'(dlv_dmode);
                    rec_lg[dcount]   = int'(dlv_dest_logical);
                    rec_lt[dcount]   = int'(dlv_level_trig);
                end
                dcount++;
            end
            for (int i = 0; i < N; i++) begin
                if (coalesced[i]) co_cnt[i]++;
                if (eoi_ack[i])   ack_cnt[i]++;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_eff(input int p, input bit v);
        cur_eff[p]   = v;
        pin_level[p] = v ^ ent_active_low[p];
    endtask

    task automatic wr_entry(input int p, input bit lvl, input bit alow,
                            input bit msk, input logic [7:0] vec);
        ent_vector[p*8 +: 8]  = vec;
        ent_dest[p*8 +: 8]    = 8'(8'h80 + p);
        ent_dest_logical[p]   = p[0];
        ent_level_trig[p]     = lvl;
        ent_dmode[p*3 +: 3]   = p[2:0];
        ent_active_low[p]     = alow;
        ent_mask[p]           = msk;
        pin_level[p]          = cur_eff[p] ^ alow;
        ent_wr[p]             = 1'b1;
        @(negedge clk);
        ent_wr[p]             = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v, input bit lvl);
        eoi_vector = v;
        eoi_level  = lvl;
        eoi_valid  = 1'b1;
        @(negedge clk);
        eoi_valid  = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        int b0;
        int exp_seq[7];

        tick(3);
        chk("R13", "dlv_valid in reset", int'(dlv_valid), 0);
        chk("R13", "coalesced in reset", int'(coalesced), 0);
        rst = 1'b0;
        tick(1);
        chk("R13", "eoi_ack after reset", int'(eoi_ack), 0);

        // R10: map cleared by reset, nothing acknowledged before any write
        for (int p = 0; p < N; p++) ent_vector[p*8 +: 8] = 8'(8'h40 + p);
        eoi(8'h40, 1'b1);
        tick(2);
        chk("R10", "ack before any write", ack_cnt[0], 0);

        for (int p = 0; p < N; p++) wr_entry(p, 1'b0, 1'b0, 1'b0, 8'(8'h40 + p));
        tick(3);

        // R1 R2 R6: every pin, both polarities
        for (int p = 0; p < N; p++) begin
            for (int a = 0; a < 2; a++) begin
                wr_entry(p, 1'b0, a[0], 1'b0, 8'(8'h40 + p));
                tick(3);
                base = dcount;
                set_eff(p, 1'b1);
                tick(6);
                chk(a ? "R1" : "R2", "edge delivery count", dcount - base, 1);
                chk("R6", "pin", rec_pin[base], p);
                chk("R6", "vector", rec_vec[base], 'h40 + p);
                chk("R6", "dest", rec_dest[base], 'h80 + p);
                chk("R6", "dmode", rec_dm[base], p % 8);
                chk("R6", "dest mode", rec_lg[base], p % 2);
                chk("R6", "trigger", rec_lt[base], 0);
                tick(5);
                chk("R2", "held high no repeat", dcount - base, 1);
                set_eff(p, 1'b0);
                tick(4);
                chk("R2", "falling no delivery", dcount - base, 1);
                wr_entry(p, 1'b0, 1'b0, 1'b0, 8'(8'h40 + p));
            end
        end

        // R5 masked, R11 edge write does nothing
        wr_entry(2, 1'b0, 1'b0, 1'b1, 8'h42);
        base = dcount;
        set_eff(2, 1'b1);
        tick(6);
        chk("R5", "masked rise", dcount - base, 0);
        wr_entry(2, 1'b0, 1'b0, 1'b0, 8'h42);
        tick(6);
        chk("R11", "edge write no service", dcount - base, 0);
        set_eff(2, 1'b0);
        tick(2);

        // R3 R4 R8 R9 on level pin 3
        wr_entry(3, 1'b1, 1'b0, 1'b0, 8'h43);
        tick(2);
        base = dcount;
        set_eff(3, 1'b1);
        tick(6);
        chk("R3", "level first delivery", dcount - base, 1);
        chk("R3", "level trig bit", rec_lt[base], 1);
        set_eff(3, 1'b0);
        tick(2);
        b0 = co_cnt[3];
        set_eff(3, 1'b1);
        tick(6);
        chk("R4", "no delivery while in service", dcount - base, 1);
        chk("R4", "coalesced pulse", co_cnt[3] - b0, 1);
        b0 = ack_cnt[3];
        eoi(8'h43, 1'b1);
        tick(6);
        chk("R8", "ack on level notice", ack_cnt[3] - b0, 1);
        chk("R9", "redelivery while high", dcount - base, 2);
        set_eff(3, 1'b0);
        tick(2);
        eoi(8'h43, 1'b1);
        tick(6);
        chk("R9", "no redelivery when low", dcount - base, 2);
        set_eff(3, 1'b1);
        tick(6);
        chk("R9", "released pin delivers", dcount - base, 3);
        set_eff(3, 1'b0);
        tick(2);
        eoi(8'h43, 1'b0);
        tick(2);
        b0 = co_cnt[3];
        set_eff(3, 1'b1);
        tick(6);
        chk("R9", "non-level notice keeps in service", co_cnt[3] - b0, 1);
        chk("R9", "non-level notice no delivery", dcount - base, 3);
        set_eff(3, 1'b0);
        tick(2);
        eoi(8'h43, 1'b1);
        tick(3);

        // R3 refused delivery leaves remote-IRR clear
        dlv_ok = 1'b0;
        base = dcount;
        b0 = co_cnt[3];
        set_eff(3, 1'b1);
        tick(6);
        set_eff(3, 1'b0);
        tick(2);
        set_eff(3, 1'b1);
        tick(6);
        chk("R3", "refused deliveries repeat", dcount - base, 2);
        chk("R3", "refused no coalesce", co_cnt[3] - b0, 0);
        set_eff(3, 1'b0);
        dlv_ok = 1'b1;
        tick(2);

        // R8 shared vector acknowledges both pins
        wr_entry(5, 1'b1, 1'b0, 1'b0, 8'h43);
        tick(1);
        b0 = ack_cnt[5];
        base = ack_cnt[3];
        eoi(8'h43, 1'b0);
        tick(2);
        chk("R8", "shared vector pin3", ack_cnt[3] - base, 1);
        chk("R8", "shared vector pin5", ack_cnt[5] - b0, 1);
        wr_entry(5, 1'b0, 1'b0, 1'b0, 8'h45);

        // R10 vector map gating
        b0 = ack_cnt[4];
        eoi(8'h99, 1'b1);
        tick(2);
        chk("R10", "absent vector ignored", ack_cnt[4] - b0, 0);
        ent_vector[4*8 +: 8] = 8'h99;
        tick(1);
        eoi(8'h99, 1'b1);
        tick(2);
        chk("R10", "stale map ignores new vector", ack_cnt[4] - b0, 0);
        ent_wr[4] = 1'b1;
        tick(1);
        ent_wr[4] = 1'b0;
        eoi(8'h99, 1'b1);
        tick(2);
        chk("R10", "rebuilt map accepts", ack_cnt[4] - b0, 1);
        eoi(8'h44, 1'b1);
        tick(2);
        chk("R10", "old vector dropped", ack_cnt[4] - b0, 1);
        wr_entry(4, 1'b0, 1'b0, 1'b0, 8'h44);

        // R11 entry write redelivers a high level pin
        wr_entry(6, 1'b1, 1'b0, 1'b0, 8'h46);
        base = dcount;
        set_eff(6, 1'b1);
        tick(6);
        chk("R11", "first level delivery", dcount - base, 1);
        wr_entry(6, 1'b1, 1'b0, 1'b0, 8'h46);
        tick(6);
        chk("R11", "write redelivers", dcount - base, 2);
        wr_entry(6, 1'b1, 1'b0, 1'b0, 8'h46);
        tick(6);
        chk("R11", "second write redelivers", dcount - base, 3);
        set_eff(6, 1'b0);
        tick(2);
        wr_entry(6, 1'b1, 1'b0, 1'b0, 8'h46);
        tick(6);
        chk("R11", "write with low level", dcount - base, 3);
        eoi(8'h46, 1'b1);
        tick(2);

        // R7 ordering with pin 2 masked, R6 stall stability
        for (int p = 0; p < N; p++) wr_entry(p, 1'b0, 1'b0, (p == 2), 8'(8'h40 + p));
        tick(2);
        dlv_ready = 1'b0;
        for (int p = 0; p < N; p++) set_eff(p, 1'b1);
        tick(4);
        chk("R7", "first launch valid", int'(dlv_valid), 1);
        chk("R7", "lowest pin first", int'(dlv_pin), 0);
        tick(3);
        chk("R6", "stall keeps pin", int'(dlv_pin), 0);
        chk("R6", "stall keeps vector", int'(dlv_vector), 'h40);
        base = dcount;
        dlv_ready = 1'b1;
        tick(25);
        chk("R7", "deliveries skipping masked", dcount - base, 7);
        exp_seq = '{0, 1, 3, 4, 5, 6, 7};
        for (int k = 0; k < 7; k++) chk("R7", "order", rec_pin[base + k], exp_seq[k]);
        for (int p = 0; p < N; p++) set_eff(p, 1'b0);
        tick(2);
        wr_entry(2, 1'b0, 1'b0, 1'b0, 8'h42);
        tick(2);

        // R12 accepted delivery and level notice on the same pin together
        wr_entry(3, 1'b1, 1'b0, 1'b0, 8'h43);
        tick(2);
        base = dcount;
        set_eff(3, 1'b1);
        tick(6);
        chk("R12", "setup delivery", dcount - base, 1);
        dlv_ready = 1'b0;
        eoi(8'h43, 1'b1);
        tick(4);
        chk("R12", "redelivery held", int'(dlv_valid), 1);
        dlv_ready  = 1'b1;
        dlv_ok     = 1'b1;
        eoi_vector = 8'h43;
        eoi_level  = 1'b1;
        eoi_valid  = 1'b1;
        @(negedge clk);
        eoi_valid  = 1'b0;
        dlv_ok     = 1'b0;
        tick(6);
        chk("R12", "held plus requeued", dcount - base, 3);
        dlv_ok = 1'b1;
        set_eff(3, 1'b0);
        tick(2);
        b0 = co_cnt[3];
        set_eff(3, 1'b1);
        tick(6);
        chk("R12", "set wins coalesce", co_cnt[3] - b0, 1);
        chk("R12", "set wins no delivery", dcount - base, 3);
        set_eff(3, 1'b0);
        tick(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule